// File: doc/BRIEF.md
# Dual-Mode H-Bridge Gate Decoder

This block converts the logic-level commands for one H-bridge into four gate-enable lines: a high-side and a low-side enable for each of the two half-bridge legs. A mode input picks how the two command inputs are read. In direct mode each input drives one leg. In phase/enable mode one input gives the direction and the other turns drive on or off. The commands decode to coast (both legs floating), brake (both legs pulled low), forward or reverse.

Each leg has its own dead-time guard. When a leg swaps from its high switch to its low switch, or the other way, both enables of that leg stay low for `DEAD_CYCLES` clocks before the new switch turns on. A move to the floating state, a sleep request or a bridge-disable from a fault supervisor turns the switches off on the next clock edge. A leg that has been idle long enough can turn on at once.

Top module: `hb_gate_decoder`

## Requirements
- R1: `mode_sel` = 0 selects direct mode, where `ctl_a` commands leg 1 and `ctl_b` commands leg 2. `mode_sel` = 1 selects phase/enable mode, where `ctl_a` is the phase and `ctl_b` is the enable.
- R2: Direct mode decode, written as (`ctl_a`,`ctl_b`). 00 turns all four switches off (coast). 10 drives leg 1 high and leg 2 low (forward). 01 drives leg 1 low and leg 2 high (reverse). 11 drives both legs low (brake). A leg driven high has only its `_hs` enable set. A leg driven low has only its `_ls` enable set.
- R3: Phase/enable mode with `ctl_b` = 0 drives both legs low (brake), whatever `ctl_a` is.
- R4: Phase/enable mode with `ctl_b` = 1: `ctl_a` = 1 drives leg 1 low and leg 2 high, and `ctl_a` = 0 drives leg 1 high and leg 2 low.
- R5: While `sleep_n` = 0, all four enables are 0 from the next clock edge on.
- R6: While `bridge_off` = 1, all four enables are 0 from the next clock edge on. This overrides every decoded state.
- R7: Enables are registered. A command sampled at a rising edge takes effect at the output right after that edge, unless a dead-time wait holds it back.
- R8: When a leg is commanded straight from one side to the other, both of its enables are 0 for exactly `DEAD_CYCLES` cycles before the new side turns on.
- R9: A command to float a leg turns both of its enables off at the next edge, with no delay.
- R10: A leg turns on a side at once if the opposite side has been off for at least `DEAD_CYCLES` cycles, and this includes a return to the side that was last on. Otherwise it stays off until that count is reached, counting from the moment the opposite side turned off for any reason.
- R11: The high and low enables of one leg are never 1 in the same cycle, and a side never turns on fewer than `DEAD_CYCLES` cycles after the opposite side of its leg turned off.
- R12: While `rst_n` = 0 at a rising edge, all four enables are 0 after that edge. No dead-time wait is pending after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 1 | 0 = direct mode, 1 = phase/enable mode |
| ctl_a | input | 1 | Leg 1 command (direct) or phase (phase/enable) |
| ctl_b | input | 1 | Leg 2 command (direct) or enable (phase/enable) |
| sleep_n | input | 1 | 0 turns all switches off |
| bridge_off | input | 1 | Fault supervisor disable, 1 turns all switches off |
| out1_hs | output | 1 | Leg 1 high-side gate enable |
| out1_ls | output | 1 | Leg 1 low-side gate enable |
| out2_hs | output | 1 | Leg 2 high-side gate enable |
| out2_ls | output | 1 | Leg 2 low-side gate enable |

## Verification
Every command sampled at a rising edge is due on the enables just after that edge. The only exception is a swap to the opposite side, which is due `DEAD_CYCLES` edges after the edge that turned the old side off. The bench changes inputs on the falling edge. Its behavioural model records, per leg and per side, the edge at which that side last turned off, and it is advanced at each rising edge. All four enables are compared with the model at the next falling edge, so each check samples half a cycle after the edge where the result is due.

// File: rtl/hb_pkg.sv
// Shared types for the H-bridge gate decoder.
// Assumes: a leg is either floating, driven high or driven low.
package hb_pkg;
    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_HIGH = 2'd1,
        LEG_LOW  = 2'd2
    } leg_state_t;
endpackage

// File: rtl/hb_mode_decoder.sv
// Decodes the two command inputs into a target state per leg.
// Pure combinational; does not consider sleep or the fault disable.
// Assumes: cmd_a/cmd_b are already synchronous to the block clock.
module hb_mode_decoder
    import hb_pkg::*;
(
    input  logic       phase_mode,
    input  logic       cmd_a,
    input  logic       cmd_b,
    output leg_state_t leg1_tgt,
    output leg_state_t leg2_tgt
);
    // Selects the decode table for the active mode.
    always_comb begin
        leg1_tgt = LEG_OFF;
        leg2_tgt = LEG_OFF;
        if (phase_mode) begin
            // cmd_b is the enable, cmd_a the direction
            if (!cmd_b) begin
                leg1_tgt = LEG_LOW;
                leg2_tgt = LEG_LOW;
            end else if (cmd_a) begin
                leg1_tgt = LEG_LOW;
                leg2_tgt = LEG_HIGH;
            end else begin
                leg1_tgt = LEG_HIGH;
                leg2_tgt = LEG_LOW;
            end
        end else begin
            unique case ({cmd_a, cmd_b})
                2'b00: begin
                    leg1_tgt = LEG_OFF;
                    leg2_tgt = LEG_OFF;
                end
                2'b10: begin
                    leg1_tgt = LEG_HIGH;
                    leg2_tgt = LEG_LOW;
                end
                2'b01: begin
                    leg1_tgt = LEG_LOW;
                    leg2_tgt = LEG_HIGH;
                end
                default: begin
                    leg1_tgt = LEG_LOW;
                    leg2_tgt = LEG_LOW;
                end
            endcase
        end
    end
endmodule

// File: rtl/hb_leg_guard.sv
// Per-leg switch sequencer with dead-time protection.
// Turns a target state into registered high/low gate enables. A swap
// between sides passes through DEAD_CYCLES cycles of both-off; turning
// off (target off or force_off) is immediate.
// Assumes: DEAD_CYCLES >= 1.
module hb_leg_guard
    import hb_pkg::*;
#(
    parameter int DEAD_CYCLES = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       force_off,
    input  leg_state_t tgt,
    output logic       hs_en,
    output logic       ls_en
);
    localparam int CW = $clog2(DEAD_CYCLES + 1);
    localparam logic [CW-1:0] DEAD_LOAD = CW'(DEAD_CYCLES - 1);
    localparam logic [CW-1:0] DEAD_FULL = CW'(DEAD_CYCLES);

    leg_state_t    cur_q, cur_d;
    leg_state_t    last_q, last_d;
    logic [CW-1:0] wait_q, wait_d;
    logic [CW-1:0] wait_dec;

    // Remaining dead time counts down to zero and holds there.
    assign wait_dec = (wait_q != '0) ? wait_q - 1'b1 : '0;

    // Next-state selection for the leg.
    always_comb begin
        cur_d  = cur_q;
        last_d = last_q;
        wait_d = wait_q;
        if (force_off || tgt == LEG_OFF) begin
            if (cur_q != LEG_OFF) begin
                cur_d  = LEG_OFF;
                last_d = cur_q;
                wait_d = DEAD_LOAD;
            end else begin
                wait_d = wait_dec;
            end
        end else if (tgt == cur_q) begin
            wait_d = '0;
        end else if (cur_q != LEG_OFF) begin
            cur_d  = LEG_OFF;
            last_d = cur_q;
            wait_d = DEAD_LOAD;
        end else if (wait_q == '0 || tgt == last_q) begin
            cur_d  = tgt;
            wait_d = '0;
        end else begin
            wait_d = wait_dec;
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= LEG_OFF;
            last_q <= LEG_LOW;
            wait_q <= '0;
        end else begin
            cur_q  <= cur_d;
            last_q <= last_d;
            wait_q <= wait_d;
        end
    end

    assign hs_en = (cur_q == LEG_HIGH);
    assign ls_en = (cur_q == LEG_LOW);

    // Observation counters: cycles each side has been off, saturating.
    logic [CW-1:0] hs_gap_q, ls_gap_q;

    // Tracks off-time of each side for the dead-time assertions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_gap_q <= DEAD_FULL;
            ls_gap_q <= DEAD_FULL;
        end else begin
            hs_gap_q <= hs_en ? '0 : ((hs_gap_q == DEAD_FULL) ? hs_gap_q : hs_gap_q + 1'b1);
            ls_gap_q <= ls_en ? '0 : ((ls_gap_q == DEAD_FULL) ? ls_gap_q : ls_gap_q + 1'b1);
        end
    end

    // R11
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    // R11
    ls_dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> (hs_gap_q >= DEAD_FULL));

    // R11
    hs_dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> (ls_gap_q >= DEAD_FULL));

    // R9
    float_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == LEG_OFF) |=> (!hs_en && !ls_en));
endmodule

// File: rtl/hb_gate_decoder.sv
// Top of the H-bridge gate decoder: mode decode followed by one dead-time
// guard per leg. Sleep and the fault disable are merged into one
// force-off that acts at the next edge.
// Assumes: all inputs synchronous to clk.
module hb_gate_decoder
    import hb_pkg::*;
#(
    parameter int DEAD_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sel,
    input  logic ctl_a,
    input  logic ctl_b,
    input  logic sleep_n,
    input  logic bridge_off,
    output logic out1_hs,
    output logic out1_ls,
    output logic out2_hs,
    output logic out2_ls
);
    localparam int NUM_LEGS = 2;

    leg_state_t          leg_tgt [NUM_LEGS];
    logic [NUM_LEGS-1:0] hs_vec;
    logic [NUM_LEGS-1:0] ls_vec;
    logic                kill;

    // Any shutdown source forces every switch off.
    assign kill = !sleep_n || bridge_off;

    hb_mode_decoder u_decode (
        .phase_mode (mode_sel),
        .cmd_a      (ctl_a),
        .cmd_b      (ctl_b),
        .leg1_tgt   (leg_tgt[0]),
        .leg2_tgt   (leg_tgt[1])
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hb_leg_guard #(
            .DEAD_CYCLES (DEAD_CYCLES)
        ) u_guard (
            .clk       (clk),
            .rst_n     (rst_n),
            .force_off (kill),
            .tgt       (leg_tgt[g]),
            .hs_en     (hs_vec[g]),
            .ls_en     (ls_vec[g])
        );
    end

    assign out1_hs = hs_vec[0];
    assign out1_ls = ls_vec[0];
    assign out2_hs = hs_vec[1];
    assign out2_ls = ls_vec[1];

    // R5
    sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |=> ({out1_hs, out1_ls, out2_hs, out2_ls} == 4'b0000));

    // R6
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bridge_off |=> ({out1_hs, out1_ls, out2_hs, out2_ls} == 4'b0000));

    // R3
    pe_brake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && !ctl_b && sleep_n && !bridge_off) |=> (!out1_hs && !out2_hs));
endmodule

// File: tb/hb_gate_decoder_tb.sv
module hb_gate_decoder_tb;
    localparam int DEAD = 10;

    logic clk = 1'b0;
    logic rst_n, mode_sel, ctl_a, ctl_b, sleep_n, bridge_off;
    logic out1_hs, out1_ls, out2_hs, out2_ls;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model: state per leg 0 off, 1 high, 2 low; off_at[leg][side] edge index
    int m_st [2];
    int off_at [2][2];
    int edge_n = 0;

    always #5 clk = ~clk;

    hb_gate_decoder #(.DEAD_CYCLES(DEAD)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ctl_a(ctl_a),
        .ctl_b(ctl_b), .sleep_n(sleep_n), .bridge_off(bridge_off),
        .out1_hs(out1_hs), .out1_ls(out1_ls), .out2_hs(out2_hs), .out2_ls(out2_ls)
    );

    // R1 R2 R3 R4: wanted leg state from the decode tables
    function automatic int want(input bit md, input bit a, input bit b, input int leg);
        int r1, r2;
        if (!md) begin
            if (!a && !b) begin r1 = 0; r2 = 0; end
            else if (a && !b) begin r1 = 1; r2 = 2; end
            else if (!a && b) begin r1 = 2; r2 = 1; end
            else begin r1 = 2; r2 = 2; end
        end else begin
            if (!b) begin r1 = 2; r2 = 2; end
            else if (a) begin r1 = 2; r2 = 1; end
            else begin r1 = 1; r2 = 2; end
        end
        return (leg == 0) ? r1 : r2;
    endfunction

    task automatic model_reset();
        for (int l = 0; l < 2; l++) begin
            m_st[l] = 0;
            off_at[l][0] = -1000;
            off_at[l][1] = -1000;
        end
    endtask

    task automatic model_edge();
        bit kill;
        kill = !sleep_n || bridge_off;
        edge_n++;
        for (int l = 0; l < 2; l++) begin
            int t;
            t = kill ? 0 : want(mode_sel, ctl_a, ctl_b, l);
            if (t == 0) begin
                if (m_st[l] != 0) off_at[l][m_st[l]-1] = edge_n;
                m_st[l] = 0;
            end else if (t != m_st[l]) begin
                if (m_st[l] != 0) begin
                    off_at[l][m_st[l]-1] = edge_n;
                    m_st[l] = 0;
                end else if (edge_n - off_at[l][(t == 1) ? 1 : 0] >= DEAD) begin
                    m_st[l] = t;
                end
            end
        end
    endtask

    task automatic compare(input string req);
        logic [3:0] exp_v, got_v;
        exp_v = {m_st[0] == 1, m_st[0] == 2, m_st[1] == 1, m_st[1] == 2};
        got_v = {out1_hs, out1_ls, out2_hs, out2_ls};
        checks++;
        if (got_v !== exp_v) begin
            errors++;
            $display("FAIL %s edge %0d: enables got %b expected %b", req, edge_n, got_v, exp_v);
        end
        // R11: a leg never has both switches on
        if ((out1_hs && out1_ls) || (out2_hs && out2_ls)) begin
            checks++;
            errors++;
            $display("FAIL R11 edge %0d: overlap got %b expected no pair", edge_n, got_v);
        end
    endtask

    // One cycle: apply inputs after a falling edge, step the model at the rising edge,
    // compare at the following falling edge.
    task automatic step(input bit md, input bit a, input bit b, input bit slp,
                        input bit off, input string req);
        mode_sel = md; ctl_a = a; ctl_b = b; sleep_n = slp; bridge_off = off;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(req);
    endtask

    task automatic hold(input int n, input bit md, input bit a, input bit b,
                        input bit slp, input bit off, input string req);
        for (int i = 0; i < n; i++) step(md, a, b, slp, off, req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run got hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode_sel = 1'b0; ctl_a = 1'b1; ctl_b = 1'b0;
        sleep_n = 1'b1; bridge_off = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state all off even with a forward command present
        compare("R12");
        rst_n = 1'b1;

        // R2 R7: direct mode table, each held long enough to settle
        hold(3,  0, 1, 0, 1, 0, "R7");
        hold(15, 0, 1, 0, 1, 0, "R2");
        hold(15, 0, 1, 1, 1, 0, "R2");
        hold(15, 0, 0, 0, 1, 0, "R2");
        hold(15, 0, 0, 1, 1, 0, "R2");
        // R8: direct swap forward <-> reverse
        hold(15, 0, 1, 0, 1, 0, "R8");
        hold(15, 0, 0, 1, 1, 0, "R8");
        // R9: float takes effect at once
        hold(3,  0, 0, 0, 1, 0, "R9");
        // R10: after 3 cycles of float, reverse side still waits
        hold(2,  0, 1, 0, 1, 0, "R10");
        hold(15, 0, 1, 0, 1, 0, "R10");
        // R10: swap requested then reverted quickly returns at once
        hold(2,  0, 0, 1, 1, 0, "R10");
        hold(5,  0, 1, 0, 1, 0, "R10");
        // R1 R3 R4: phase/enable mode
        hold(15, 1, 1, 0, 1, 0, "R3");
        hold(15, 1, 0, 0, 1, 0, "R3");
        hold(15, 1, 1, 1, 1, 0, "R4");
        hold(15, 1, 0, 1, 1, 0, "R4");
        hold(15, 0, 0, 1, 1, 0, "R1");
        hold(15, 1, 0, 1, 1, 0, "R1");
        // R5: sleep
        hold(5,  1, 0, 1, 0, 0, "R5");
        hold(15, 1, 1, 1, 1, 0, "R5");
        // R6: fault disable overrides, also against sleep release
        hold(5,  1, 1, 1, 1, 1, "R6");
        hold(5,  0, 1, 1, 1, 1, "R6");
        hold(15, 0, 1, 1, 1, 0, "R6");

        // R8 R10 R11: mixed pseudo-random traffic, inputs held random lengths
        for (int k = 0; k < 400; k++) begin
            bit md, a, b, slp, off;
            int len;
            md  = 1'($urandom_range(0, 1));
            a   = 1'($urandom_range(0, 1));
            b   = 1'($urandom_range(0, 1));
            slp = ($urandom_range(0, 15) != 0);
            off = ($urandom_range(0, 15) == 0);
            len = $urandom_range(1, 2 * DEAD);
            hold(len, md, a, b, slp, off, "R11");
        end

        // R12: reset mid-drive clears and leaves no pending wait
        hold(15, 0, 1, 0, 1, 0, "R2");
        rst_n = 1'b0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        compare("R12");
        rst_n = 1'b1;
        hold(2, 0, 0, 1, 1, 0, "R12");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule